// File: doc/BRIEF.md
# I2C Bus Hang Watchdog

This block watches each transfer that an I2C master controller carries out. It recovers the controller when a stuck slave keeps the transfer from finishing. A start pulse captures the transfer's total byte count and the bus clock rate, then arms a deadline. The deadline is a fixed 100 ms allowance plus nine bit periods for every byte, because each byte is followed by an acknowledge bit. The block's clock rate is a parameter, and all times are counted in its cycles. A done pulse from the transfer logic disarms the deadline.

When the deadline runs out, the block turns off every controller interrupt and drops the controller enable. It then waits until the controller reports that it is inactive. After that it holds the enable low for a fixed 10 ms so the bus can clear. It then raises the enable again and waits until the controller reports that it is active. At that point it issues a one-cycle timeout pulse, which is a completion status separate from "ok" and "error". After recovery the error interrupts are turned back on. The data-level interrupts stay off until the next transfer is accepted.

Top module: `i2c_hang_wdog`

## Requirements
- R1: Let the start pulse be sampled on clock edge s, and let BASE_CYC = CLK_HZ/1000*BASE_MS. Then `ctrl_en_o` falls on edge s + BASE_CYC + ceil(9*N*CLK_HZ/F) + 1. N is the byte count and F is the bus rate, both captured at start, with 1 <= F <= CLK_HZ. A start that arrives while a deadline is already armed reloads the deadline.
- R2: A done pulse while a deadline is armed, with no start in the same cycle, cancels the deadline, so no recovery takes place.
- R3: On the edge where the deadline expires, all six bits of `irq_en_o` go to 0, `ctrl_en_o` goes to 0 and `busy_o` goes to 1.
- R4: `ctrl_en_o` stays low until `ctrl_active_i` is sampled low.
- R5: The settle interval begins on the edge that samples `ctrl_active_i` low. `ctrl_en_o` rises exactly SETTLE_CYC = CLK_HZ/1000*SETTLE_MS edges after that edge.
- R6: The edge that samples `ctrl_active_i` high while the enable is raised again ends the recovery. After that edge, `timeout_o` is high for exactly one cycle, `busy_o` is 0, and the error enables `irq_en_o[3:0]` (abort, TX overflow, RX overflow, RX underflow) are all 1.
- R7: The data enables `irq_en_o[5:4]` (bit 4 TX-empty, bit 5 RX-full) follow `data_irq_en_i` while the block is not squelched. The squelch starts at expiry and lasts until the next accepted start, and during it both bits read 0.
- R8: While `busy_o` is high, `start_i` and `done_i` are ignored. No new deadline is armed, the squelch is not lifted, and the recovery timing is unchanged.
- R9: After reset, `ctrl_en_o` = 1, `irq_en_o[3:0]` = 4'b1111, `irq_en_o[5:4]` follows `data_irq_en_i`, and `busy_o` and `timeout_o` are both 0.
- R10: If start and done are both high in the same cycle, start wins and arms a new deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transfer start pulse |
| done_i | input | 1 | Transfer completed normally |
| byte_cnt_i | input | BYTE_W | Total bytes in the transfer, captured at start |
| bus_hz_i | input | HZ_W | Bus bit rate in Hz, captured at start |
| ctrl_active_i | input | 1 | Controller reports that it is enabled |
| data_irq_en_i | input | 2 | Data-level interrupt enables requested by the transfer logic |
| ctrl_en_o | output | 1 | Controller enable |
| irq_en_o | output | 6 | Interrupt enables: [0] abort, [1] TX overflow, [2] RX overflow, [3] RX underflow, [4] TX-empty, [5] RX-full |
| busy_o | output | 1 | Recovery in progress |
| timeout_o | output | 1 | One-cycle timeout completion pulse |

## Verification
Expiry is driven with these cases:
- A bus rate that does not divide the clock rate, which checks that the deadline rounds up to a whole bit period.
- A rate equal to the clock rate, which gives one cycle per bit.
- A zero-byte transfer, which leaves only the fixed allowance.

Controller acknowledge lags of 0, 1, 2 and 4 cycles separate status polling from fixed waits. A done pulse alone and a start with done in the same cycle separate cancellation from re-arming. Start and done pulses injected during the settle interval show whether recovery really ignores them.

// File: rtl/i2c_hang_wdog_pkg.sv
package i2c_hang_wdog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WATCH,
    ST_DROP,
    ST_SETTLE,
    ST_RAISE
  } wd_state_e;

  localparam int N_ERR_IRQ  = 4;
  localparam int N_DATA_IRQ = 2;
  localparam int N_IRQ      = N_ERR_IRQ + N_DATA_IRQ;
endpackage

// File: rtl/i2c_hang_wdog_deadline.sv
module i2c_hang_wdog_deadline #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int BASE_CYC = 5_000_000,
  parameter int BITS_W   = 20,
  parameter int HZ_W     = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic [HZ_W-1:0]   hz_i,
  output logic              expired_o
);
  localparam int BASE_W = $clog2(BASE_CYC + 1);
  localparam int ACC_W  = $clog2(CLK_HZ + 1);
  localparam int SUM_W  = ((ACC_W > HZ_W) ? ACC_W : HZ_W) + 1;

  logic [BASE_W-1:0] base_q;
  logic [ACC_W-1:0]  acc_q;
  logic [BITS_W-1:0] bit_q, tgt_q;
  logic [HZ_W-1:0]   hz_q;
  logic              base_done, tick;
  logic [SUM_W-1:0]  sum;

  assign base_done = (base_q == BASE_W'(BASE_CYC));
  // fractional bit-period accumulator: one tick per elapsed bus bit
  assign sum       = SUM_W'(acc_q) + SUM_W'(hz_q);
  assign tick      = (sum >= SUM_W'(CLK_HZ));
  assign expired_o = base_done && (bit_q == tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      acc_q  <= '0;
      bit_q  <= '0;
      tgt_q  <= '0;
      hz_q   <= '0;
    end else if (load_i) begin
      base_q <= '0;
      acc_q  <= '0;
      bit_q  <= '0;
      tgt_q  <= bits_i;
      hz_q   <= hz_i;
    end else if (run_i) begin
      if (!base_done) begin
        base_q <= base_q + 1'b1;
      end else if (bit_q != tgt_q) begin
        if (tick) begin
          acc_q <= ACC_W'(sum - SUM_W'(CLK_HZ));
          bit_q <= bit_q + 1'b1;
        end else begin
          acc_q <= ACC_W'(sum);
        end
      end
    end
  end

  // R1
  deadline_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !expired_o);
endmodule

// File: rtl/i2c_hang_wdog_interval.sv
module i2c_hang_wdog_interval #(
  parameter int CYC = 500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q == CNT_W'(CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clear_i)          cnt_q <= '0;
    else if (run_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  // R5
  settle_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clear_i) |=> done_o);
endmodule

// File: rtl/i2c_hang_wdog_fsm.sv
module i2c_hang_wdog_fsm
  import i2c_hang_wdog_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  input  logic expired_i,
  input  logic settle_done_i,
  input  logic ctrl_active_i,
  output logic load_o,
  output logic trip_o,
  output logic settle_clr_o,
  output logic settle_run_o,
  output logic run_o,
  output logic ctrl_en_o,
  output logic busy_o,
  output logic timeout_o
);
  wd_state_e state_q, state_d;
  logic      timeout_q;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    trip_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_WATCH;
        load_o  = 1'b1;
      end
      ST_WATCH: begin
        if (start_i) begin
          load_o = 1'b1;
        end else if (done_i) begin
          state_d = ST_IDLE;
        end else if (expired_i) begin
          state_d = ST_DROP;
          trip_o  = 1'b1;
        end
      end
      ST_DROP:   if (!ctrl_active_i) state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done_i)  state_d = ST_RAISE;
      ST_RAISE:  if (ctrl_active_i)  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      timeout_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      timeout_q <= (state_q == ST_RAISE) && ctrl_active_i;
    end
  end

  assign settle_clr_o = (state_q == ST_DROP);
  assign settle_run_o = (state_q == ST_SETTLE);
  assign run_o        = (state_q == ST_WATCH);
  assign ctrl_en_o    = !((state_q == ST_DROP) || (state_q == ST_SETTLE));
  assign busy_o       = (state_q == ST_DROP) || (state_q == ST_SETTLE) || (state_q == ST_RAISE);
  assign timeout_o    = timeout_q;

  // R2
  cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WATCH && done_i && !start_i) |=> (state_q == ST_IDLE));
  // R4
  poll_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DROP && ctrl_active_i) |=> !ctrl_en_o);
  // R5
  settle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE && !settle_done_i) |=> !ctrl_en_o);
  // R6
  pulse_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_RAISE && start_i) |=> busy_o);
endmodule

// File: rtl/i2c_hang_wdog.sv
module i2c_hang_wdog
  import i2c_hang_wdog_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BASE_MS   = 100,
  parameter int SETTLE_MS = 10,
  parameter int BYTE_W    = 16,
  parameter int HZ_W      = 20
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  done_i,
  input  logic [BYTE_W-1:0]     byte_cnt_i,
  input  logic [HZ_W-1:0]       bus_hz_i,
  input  logic                  ctrl_active_i,
  input  logic [N_DATA_IRQ-1:0] data_irq_en_i,
  output logic                  ctrl_en_o,
  output logic [N_IRQ-1:0]      irq_en_o,
  output logic                  busy_o,
  output logic                  timeout_o
);
  localparam int BASE_CYC   = CLK_HZ / 1000 * BASE_MS;
  localparam int SETTLE_CYC = CLK_HZ / 1000 * SETTLE_MS;
  localparam int BITS_W     = BYTE_W + 4;

  logic              load, trip, run, expired;
  logic              settle_clr, settle_run, settle_done;
  logic              squelch_q;
  logic [BITS_W-1:0] bits;

  // nine bit periods per byte: data plus acknowledge
  assign bits = (BITS_W'(byte_cnt_i) << 3) + BITS_W'(byte_cnt_i);

  i2c_hang_wdog_deadline #(
    .CLK_HZ(CLK_HZ), .BASE_CYC(BASE_CYC), .BITS_W(BITS_W), .HZ_W(HZ_W)
  ) u_deadline (
    .clk_i, .rst_ni, .load_i(load), .run_i(run),
    .bits_i(bits), .hz_i(bus_hz_i), .expired_o(expired)
  );

  i2c_hang_wdog_interval #(.CYC(SETTLE_CYC)) u_settle (
    .clk_i, .rst_ni, .clear_i(settle_clr), .run_i(settle_run), .done_o(settle_done)
  );

  i2c_hang_wdog_fsm u_fsm (
    .clk_i, .rst_ni, .start_i, .done_i,
    .expired_i(expired), .settle_done_i(settle_done), .ctrl_active_i,
    .load_o(load), .trip_o(trip), .settle_clr_o(settle_clr),
    .settle_run_o(settle_run), .run_o(run),
    .ctrl_en_o, .busy_o, .timeout_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   squelch_q <= 1'b0;
    else if (load) squelch_q <= 1'b0;
    else if (trip) squelch_q <= 1'b1;
  end

  assign irq_en_o = {data_irq_en_i & {N_DATA_IRQ{!squelch_q}}, {N_ERR_IRQ{!busy_o}}};

  // R3
  trip_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip |=> (irq_en_o == '0 && !ctrl_en_o && busy_o));
  // R7
  data_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (irq_en_o[N_IRQ-1:N_ERR_IRQ] == '0));
  // R6
  err_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (irq_en_o[N_ERR_IRQ-1:0] == '1 && ctrl_en_o));
endmodule

// File: tb/i2c_hang_wdog_tb_top.sv
module i2c_hang_wdog_tb_top;
  localparam int CLK_HZ = 100_000;
  localparam int BASE   = CLK_HZ / 1000 * 100;
  localparam int SETTLE = CLK_HZ / 1000 * 10;
  localparam int BYTE_W = 8;
  localparam int HZ_W   = 17;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0, done_i = 1'b0;
  logic [BYTE_W-1:0] byte_cnt_i = '0;
  logic [HZ_W-1:0]   bus_hz_i = '0;
  logic              ctrl_active_i = 1'b1;
  logic [1:0]        data_irq_en_i = 2'b11;
  logic              ctrl_en_o, busy_o, timeout_o;
  logic [5:0]        irq_en_o;

  int cyc = 0, checks = 0, fails = 0, lag = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  i2c_hang_wdog #(.CLK_HZ(CLK_HZ), .BYTE_W(BYTE_W), .HZ_W(HZ_W)) dut_i (
    .clk_i(clk), .rst_ni, .start_i, .done_i, .byte_cnt_i, .bus_hz_i,
    .ctrl_active_i, .data_irq_en_i, .ctrl_en_o, .irq_en_o, .busy_o, .timeout_o
  );

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // controller model: status follows enable after lag cycles
  initial begin
    int lcnt = 0;
    forever begin
      @(negedge clk);
      if (ctrl_en_o !== ctrl_active_i) begin
        if (lcnt >= lag) begin
          ctrl_active_i = ctrl_en_o;
          lcnt = 0;
        end else lcnt++;
      end else lcnt = 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor: each timeout pulse must match the queued cycle
  initial forever begin
    @(negedge clk);
    if (rst_ni && timeout_o) begin
      if (exp_q.size() == 0) chk("R6 unexpected timeout", cyc, -1);
      else chk("R1/R6 timeout cycle", cyc, exp_q.pop_front());
    end
  end

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic xfer(int bytes, int hz, int l, bit inject, bit with_done);
    int s, t, x, r, p;
    lag = l;
    byte_cnt_i = BYTE_W'(bytes);
    bus_hz_i   = HZ_W'(hz);
    start_i = 1'b1;
    done_i  = with_done;
    @(negedge clk);
    start_i = 1'b0;
    done_i  = 1'b0;
    s = cyc;
    chk("R7 data enables restored on start", int'(irq_en_o[5:4]), 3);
    t = int'((longint'(9) * bytes * CLK_HZ + hz - 1) / hz);
    x = s + BASE + t + 1;
    r = x + 1 + l + SETTLE;
    p = r + 1 + l;
    exp_q.push_back(p);
    wait_until(x - 1);
    chk("R1 enable before deadline", int'(ctrl_en_o), 1);
    wait_until(x);
    chk("R1 enable drops at deadline", int'(ctrl_en_o), 0);
    chk("R3 all irq enables cleared", int'(irq_en_o), 0);
    chk("R3 busy at expiry", int'(busy_o), 1);
    if (l > 0) begin
      wait_until(x + l);
      chk("R4 enable low while still active", int'(ctrl_en_o), 0);
    end
    if (inject) begin
      wait_until(x + 1 + l + SETTLE / 2);
      start_i = 1'b1;
      done_i  = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      done_i  = 1'b0;
    end
    wait_until(r - 1);
    chk("R5 enable low through settle", int'(ctrl_en_o), 0);
    wait_until(r);
    chk("R5 enable rises after settle", int'(ctrl_en_o), 1);
    chk("R6 still busy before active", int'(busy_o), 1);
    wait_until(p);
    chk("R6 busy cleared", int'(busy_o), 0);
    chk("R6 error enables back", int'(irq_en_o[3:0]), 15);
    chk("R7 data enables squelched", int'(irq_en_o[5:4]), 0);
    wait_until(p + 1);
    chk("R6 single pulse", int'(timeout_o), 0);
    if (inject) begin
      wait_until(p + BASE + 300);
      chk("R8 no re-arm from ignored start", int'(ctrl_en_o), 1);
      chk("R8 squelch kept", int'(irq_en_o[5:4]), 0);
    end
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9
    chk("R9 reset enable", int'(ctrl_en_o), 1);
    chk("R9 reset irq enables", int'(irq_en_o), 63);
    chk("R9 reset busy", int'(busy_o), 0);
    chk("R9 reset timeout", int'(timeout_o), 0);
    data_irq_en_i = 2'b01;
    @(negedge clk);
    chk("R7 data pass-through", int'(irq_en_o[5:4]), 1);
    data_irq_en_i = 2'b11;

    xfer(3, 40_000, 0, 0, 0);    // fractional bit period
    xfer(10, 100_000, 4, 0, 0);  // one cycle per bit, slow acks
    xfer(0, 25_000, 2, 0, 0);    // fixed allowance only
    xfer(2, 20_000, 0, 1, 0);    // R8 injected start/done

    // R2 cancel
    lag = 0;
    byte_cnt_i = 8'd5;
    bus_hz_i   = HZ_W'(50_000);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    s = cyc;
    wait_until(s + 500);
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    wait_until(s + BASE + 1000);
    chk("R2 enable kept after cancel", int'(ctrl_en_o), 1);
    chk("R2 no recovery after cancel", int'(busy_o), 0);
    chk("R2 data enables unsquelched", int'(irq_en_o[5:4]), 3);

    xfer(1, 50_000, 1, 0, 1);    // R10 start wins over done

    repeat (5) @(negedge clk);
    chk("R6 all timeouts seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule